// File: doc/BRIEF.md
# Dimension-Order Mesh/Torus Router

This block is the switching element of one node in a two-dimensional grid of ROWS x COLS nodes. The default grid is 4 x 4. Five ports lead in and out of the node: one local port to the attached processor, and one port toward each neighbour on the east, west, north and south. Each packet is a single flit. It carries the coordinates of its destination node and a payload. The node's own coordinates come in on plain static pins, so one design serves every position in the grid.

Routing is dimension-ordered. A packet first moves along its row until it reaches the destination column. After that it moves only along that column, and at the destination node it leaves on the local port. A compile-time option adds wraparound links, which turn every row and every column into a bidirectional ring; this is torus mode. In torus mode the router goes the shorter way around each ring. When the two ways are the same length, it takes the direction of increasing coordinate.

Each input holds one packet. Each output has its own round-robin arbiter that picks among the inputs competing for it. All ten streams use valid/ready. On an input, a flit is taken in a cycle where valid and ready are both high. Once an output raises valid, it keeps valid and the same data until ready is seen high. An input whose slot is full drops ready until its packet has left the router.

Top module: `xy_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output valid is low and every input ready is high.
- R2: A packet whose destination column (dst_x) differs from the node's my_x leaves on east (port index 1, increasing x) or west (index 2). It never leaves on north, south or local.
- R3: North (index 3, increasing y) and south (index 4) are chosen only for a packet whose dst_x equals my_x.
- R4: A packet whose destination equals (my_x, my_y) leaves on the local port (index 0).
- R5: In mesh mode the direction follows the sign of the coordinate difference. A node on the grid edge never drives an output toward a missing link.
- R6: In torus mode the router takes the ring direction with the shorter distance. On a tie it takes east or north.
- R7: A packet walked hop by hop from any source to any destination arrives after exactly the Manhattan distance in mesh mode. In torus mode it arrives after the sum over both dimensions of min(d, size-d).
- R8: An input holds at most one packet. After a flit is accepted, that input's ready is low until the packet is sent out, and it is high again in the cycle after the output handshake.
- R9: An output whose ready is low keeps valid high and its data unchanged.
- R10: When two inputs compete for one output, both packets are delivered, in consecutive cycles, with neither lost nor duplicated.
- R11: A flit accepted at a clock edge appears as valid on its chosen output in the very next cycle.
- R12: The flit layout, from most significant bit down, is {dst_y, dst_x, payload}. With the defaults these fields are 2, 2 and 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | XW | Column of this node (static) |
| my_y | input | YW | Row of this node (static) |
| in_valid | input | 5 | Per-port input valid (local, east, west, north, south) |
| in_ready | output | 5 | Per-port input ready |
| in_data | input | 5 x FLIT_W | Per-port input flit |
| out_valid | output | 5 | Per-port output valid |
| out_ready | input | 5 | Per-port output ready |
| out_data | output | 5 x FLIT_W | Per-port output flit |

## Verification
The bench walks every source and destination pair through both a mesh instance and a torus instance, one hop at a time. A router that ignored the tie rule, wrapped the wrong way, or moved vertically too early would arrive after the wrong number of hops. A mesh router that tried to leave a grid edge would be caught at that hop. Directed cases cover the exact tie at half the ring size, where a wrong tie rule sends the packet west or south instead of east or north. The bench also stalls an output and checks that valid and data stay held and that the input stays full. Two inputs are made to compete for one output; an arbiter that drops or repeats a grant would lose or duplicate a payload.

// File: rtl/xy_router_pkg.sv
package xy_router_pkg;
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/xy_route_calc.sv
module xy_route_calc
  import xy_router_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter bit TORUS = 1'b0,
  parameter int XW    = 2,
  parameter int YW    = 2
) (
  input  logic [XW-1:0] my_x,
  input  logic [YW-1:0] my_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output port_e         dir
);
  int fwd_x;
  int fwd_y;

  // distance in the increasing direction around each ring
  always_comb begin
    fwd_x = int'(dst_x) - int'(my_x);
    if (fwd_x < 0) fwd_x = fwd_x + COLS;
    fwd_y = int'(dst_y) - int'(my_y);
    if (fwd_y < 0) fwd_y = fwd_y + ROWS;
  end

  generate
    if (TORUS) begin : g_torus
      always_comb begin
        if (dst_x != my_x)
          dir = (2 * fwd_x <= COLS) ? PORT_EAST : PORT_WEST;
        else if (dst_y != my_y)
          dir = (2 * fwd_y <= ROWS) ? PORT_NORTH : PORT_SOUTH;
        else
          dir = PORT_LOCAL;
      end
    end else begin : g_mesh
      always_comb begin
        if (dst_x != my_x)
          dir = (dst_x > my_x) ? PORT_EAST : PORT_WEST;
        else if (dst_y != my_y)
          dir = (dst_y > my_y) ? PORT_NORTH : PORT_SOUTH;
        else
          dir = PORT_LOCAL;
      end
    end
  endgenerate
endmodule

// File: rtl/xy_input_slot.sv
module xy_input_slot #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready = !full_q;
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_valid && !full_q) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (pop) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xy_out_arb.sv
module xy_out_arb #(
  parameter  int N  = 5,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         out_ready,
  output logic [N-1:0] gnt,
  output logic         valid
);
  logic [PW-1:0] ptr_q;
  logic          lock_q;
  logic [N-1:0]  held_q;
  logic [N-1:0]  pick;
  logic [PW-1:0] gidx;
  logic [PW-1:0] nxt;
  logic          found;

  // rotating-priority pick starting at ptr_q
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
      end
    end
  end

  // a stalled grant stays locked so the output holds its data
  assign gnt   = lock_q ? held_q : pick;
  assign valid = |gnt;

  always_comb begin
    gidx = '0;
    for (int k = 0; k < N; k++)
      if (gnt[k]) gidx = PW'(k);
    nxt = (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lock_q <= 1'b0;
      held_q <= '0;
    end else begin
      lock_q <= valid && !out_ready;
      if (valid && !out_ready) held_q <= gnt;
      if (valid && out_ready)  ptr_q  <= nxt;
    end
  end
endmodule

// File: rtl/xy_router.sv
module xy_router
  import xy_router_pkg::*;
#(
  parameter  int ROWS   = 4,
  parameter  int COLS   = 4,
  parameter  bit TORUS  = 1'b0,
  parameter  int DATA_W = 16,
  localparam int XW     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int FLIT_W = YW + XW + DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [XW-1:0]                 my_x,
  input  logic [YW-1:0]                 my_y,
  input  logic [NPORT-1:0]              in_valid,
  output logic [NPORT-1:0]              in_ready,
  input  logic [NPORT-1:0][FLIT_W-1:0]  in_data,
  output logic [NPORT-1:0]              out_valid,
  input  logic [NPORT-1:0]              out_ready,
  output logic [NPORT-1:0][FLIT_W-1:0]  out_data
);
  logic [NPORT-1:0]             slot_full;
  logic [NPORT-1:0][FLIT_W-1:0] slot_data;
  logic [NPORT-1:0]             slot_pop;
  port_e                        slot_dir [NPORT];
  logic [NPORT-1:0][NPORT-1:0]  req;   // [output][input]
  logic [NPORT-1:0][NPORT-1:0]  gnt;   // [output][input]

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    xy_input_slot #(.W(FLIT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid[i]),
      .in_data  (in_data[i]),
      .in_ready (in_ready[i]),
      .pop      (slot_pop[i]),
      .full     (slot_full[i]),
      .data     (slot_data[i])
    );

    xy_route_calc #(
      .ROWS(ROWS), .COLS(COLS), .TORUS(TORUS), .XW(XW), .YW(YW)
    ) u_route (
      .my_x  (my_x),
      .my_y  (my_y),
      .dst_x (slot_data[i][DATA_W +: XW]),
      .dst_y (slot_data[i][DATA_W + XW +: YW]),
      .dir   (slot_dir[i])
    );

    for (genvar o = 0; o < NPORT; o++) begin : g_req
      assign req[o][i] = slot_full[i] && (int'(slot_dir[i]) == o);
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xy_out_arb #(.N(NPORT)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req[o]),
      .out_ready (out_ready[o]),
      .gnt       (gnt[o]),
      .valid     (out_valid[o])
    );

    always_comb begin
      out_data[o] = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt[o][i]) out_data[o] = slot_data[i];
    end
  end

  always_comb begin
    slot_pop = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (gnt[o][i] && out_ready[o]) slot_pop[i] = 1'b1;
  end
endmodule

// File: rtl/xy_router_chk.sv
module xy_router_chk
  import xy_router_pkg::*;
#(
  parameter  int ROWS   = 4,
  parameter  int COLS   = 4,
  parameter  bit TORUS  = 1'b0,
  parameter  int DATA_W = 16,
  localparam int XW     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int FLIT_W = YW + XW + DATA_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [XW-1:0]                 my_x,
  input logic [YW-1:0]                 my_y,
  input logic [NPORT-1:0]              in_valid,
  input logic [NPORT-1:0]              in_ready,
  input logic [NPORT-1:0]              out_valid,
  input logic [NPORT-1:0]              out_ready,
  input logic [NPORT-1:0][FLIT_W-1:0]  out_data
);
  function automatic logic [XW-1:0] fx(input logic [FLIT_W-1:0] f);
    return f[DATA_W +: XW];
  endfunction
  function automatic logic [YW-1:0] fy(input logic [FLIT_W-1:0] f);
    return f[DATA_W + XW +: YW];
  endfunction

  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0));

  p_east_needs_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[PORT_EAST] |-> fx(out_data[PORT_EAST]) != my_x);
  p_west_needs_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[PORT_WEST] |-> fx(out_data[PORT_WEST]) != my_x);

  p_north_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[PORT_NORTH] |-> fx(out_data[PORT_NORTH]) == my_x);
  p_south_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[PORT_SOUTH] |-> fx(out_data[PORT_SOUTH]) == my_x);

  p_local_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[PORT_LOCAL] |->
      (fx(out_data[PORT_LOCAL]) == my_x && fy(out_data[PORT_LOCAL]) == my_y));

  if (!TORUS) begin : g_mesh_edges
    p_no_east_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[PORT_EAST] |-> int'(my_x) != COLS - 1);
    p_no_west_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[PORT_WEST] |-> my_x != '0);
    p_no_north_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[PORT_NORTH] |-> int'(my_y) != ROWS - 1);
    p_no_south_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[PORT_SOUTH] |-> my_y != '0);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    p_one_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[p] && in_ready[p]) |=> !in_ready[p]);
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_data[p])));
  end
endmodule

bind xy_router xy_router_chk #(
  .ROWS(ROWS), .COLS(COLS), .TORUS(TORUS), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .my_x      (my_x),
  .my_y      (my_y),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_xy_router.sv
module tb_xy_router;
  localparam int N  = 5;
  localparam int FW = 20;   // {dst_y[1:0], dst_x[1:0], payload[15:0]}  (R12)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] my_x = '0;
  logic [1:0] my_y = '0;
  logic [N-1:0] in_valid = '0;
  logic [N-1:0][FW-1:0] in_data = '0;
  logic [N-1:0] out_ready = '1;
  logic sel_t = 1'b0;

  logic [N-1:0] m_in_ready, t_in_ready, m_out_valid, t_out_valid;
  logic [N-1:0][FW-1:0] m_out_data, t_out_data;
  logic [N-1:0] m_in_valid, t_in_valid;

  assign m_in_valid = sel_t ? '0 : in_valid;
  assign t_in_valid = sel_t ? in_valid : '0;

  wire [N-1:0] obs_valid = sel_t ? t_out_valid : m_out_valid;
  wire [N-1:0] obs_ready = sel_t ? t_in_ready  : m_in_ready;
  wire [N-1:0][FW-1:0] obs_data = sel_t ? t_out_data : m_out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;   // 125 MHz

  xy_router #(.ROWS(4), .COLS(4), .TORUS(1'b0), .DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(m_in_valid), .in_ready(m_in_ready), .in_data(in_data),
    .out_valid(m_out_valid), .out_ready(out_ready), .out_data(m_out_data));

  xy_router #(.ROWS(4), .COLS(4), .TORUS(1'b1), .DATA_W(16)) dut_torus (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(t_in_valid), .in_ready(t_in_ready), .in_data(in_data),
    .out_valid(t_out_valid), .out_ready(out_ready), .out_data(t_out_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dir_of(input logic [N-1:0] v);
    int d = -1;
    for (int k = 0; k < N; k++) if (v[k]) d = (d == -1) ? k : 99;
    return d;
  endfunction

  function automatic int opposite(input int d);
    case (d)
      1: return 2;
      2: return 1;
      3: return 4;
      4: return 3;
      default: return 0;
    endcase
  endfunction

  // drive one flit on a port; returns at the negedge after acceptance
  task automatic send(input int port, input int dx, input int dy, input int pl);
    @(negedge clk);
    in_data[port]  = {2'(dy), 2'(dx), 16'(pl)};
    in_valid[port] = 1'b1;
    @(negedge clk);
    in_valid[port] = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(m_out_valid == '0 && t_out_valid == '0, "R1 out_valid", int'(m_out_valid | t_out_valid), 0);
    check(m_in_ready == '1 && t_in_ready == '1, "R1 in_ready", int'(m_in_ready & t_in_ready), 31);
  endtask

  // one routing decision on the local port; the valid appears next cycle (R11)
  task automatic t_dir(input bit tor, input int x, input int y, input int dx, input int dy,
                       input int exp, input string req);
    @(negedge clk);
    sel_t = tor; my_x = 2'(x); my_y = 2'(y);
    send(0, dx, dy, 16'h1234);
    check(dir_of(obs_valid) == exp, req, dir_of(obs_valid), exp);
    check(obs_data[exp] == {2'(dy), 2'(dx), 16'h1234}, "R11 data", int'(obs_data[exp][15:0]), 16'h1234);
    @(negedge clk);
  endtask

  // hop-by-hop walk across the grid (R7)
  task automatic t_walk(input bit tor);
    for (int sx = 0; sx < 4; sx++)
      for (int sy = 0; sy < 4; sy++)
        for (int dx = 0; dx < 4; dx++)
          for (int dy = 0; dy < 4; dy++) begin
            int cx = sx, cy = sy, hops = 0, port = 0, d, exp, ax, ay;
            bit ok = 1'b1;
            bit fin = 1'b0;
            ax = (dx > sx) ? dx - sx : sx - dx;
            ay = (dy > sy) ? dy - sy : sy - dy;
            if (tor) begin
              if (4 - ax < ax) ax = 4 - ax;
              if (4 - ay < ay) ay = 4 - ay;
            end
            exp = ax + ay;
            sel_t = tor;
            while (!fin && hops <= 12) begin
              my_x = 2'(cx); my_y = 2'(cy);
              send(port, dx, dy, hops);
              d = dir_of(obs_valid);
              @(negedge clk);
              case (d)
                0: fin = 1'b1;
                1: begin if (!tor && cx == 3) ok = 1'b0; cx = (cx + 1) % 4; end
                2: begin if (!tor && cx == 0) ok = 1'b0; cx = (cx + 3) % 4; end
                3: begin if (!tor && cy == 3) ok = 1'b0; cy = (cy + 1) % 4; end
                4: begin if (!tor && cy == 0) ok = 1'b0; cy = (cy + 3) % 4; end
                default: begin ok = 1'b0; fin = 1'b1; end
              endcase
              if (d != 0) begin hops++; port = opposite(d); end
            end
            check(ok && fin && cx == dx && cy == dy && hops == exp,
                  tor ? "R7 torus hops" : "R7 mesh hops (R5 edge)", hops, exp);
          end
  endtask

  // stall an output: input slot stays full, output holds (R8, R9)
  task automatic t_stall();
    @(negedge clk);
    sel_t = 1'b0; my_x = 2'd1; my_y = 2'd1;
    out_ready = '0;
    send(2, 1, 1, 16'hBEEF);
    check(obs_ready[2] == 1'b0, "R8 full slot drops ready", int'(obs_ready[2]), 0);
    repeat (3) @(negedge clk);
    check(obs_valid[0] == 1'b1, "R9 valid held", int'(obs_valid[0]), 1);
    check(obs_data[0][15:0] == 16'hBEEF, "R9 data held", int'(obs_data[0][15:0]), 16'hBEEF);
    check(obs_ready[2] == 1'b0, "R8 still full", int'(obs_ready[2]), 0);
    out_ready = '1;
    @(negedge clk);
    check(obs_valid[0] == 1'b0, "R9 released", int'(obs_valid[0]), 0);
    check(obs_ready[2] == 1'b1, "R8 ready back", int'(obs_ready[2]), 1);
  endtask

  // two inputs compete for the local output (R10)
  task automatic t_contend();
    int p1, p2;
    @(negedge clk);
    sel_t = 1'b1; my_x = 2'd2; my_y = 2'd3;
    out_ready = '0;
    in_data[1] = {2'd3, 2'd2, 16'hAAAA}; in_valid[1] = 1'b1;
    in_data[3] = {2'd3, 2'd2, 16'h5555}; in_valid[3] = 1'b1;
    @(negedge clk);
    in_valid = '0;
    out_ready = '1;
    p1 = obs_valid[0] ? int'(obs_data[0][15:0]) : -1;
    @(negedge clk);
    p2 = obs_valid[0] ? int'(obs_data[0][15:0]) : -1;
    check((p1 == 16'hAAAA && p2 == 16'h5555) || (p1 == 16'h5555 && p2 == 16'hAAAA),
          "R10 both delivered", p1, p2);
    @(negedge clk);
    check(obs_valid[0] == 1'b0, "R10 no duplicate", int'(obs_valid[0]), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog (all R) actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_dir(0, 1, 1, 3, 2, 1, "R2 mesh east");
    t_dir(0, 1, 1, 0, 3, 2, "R2 mesh west before vertical");
    t_dir(0, 1, 1, 1, 3, 3, "R3 mesh north in column");
    t_dir(0, 2, 2, 2, 0, 4, "R3 mesh south in column");
    t_dir(0, 1, 1, 1, 1, 0, "R4 local eject");
    t_dir(0, 3, 0, 0, 0, 2, "R5 mesh edge goes west");
    t_dir(0, 0, 0, 3, 3, 1, "R5 mesh corner goes east");
    t_dir(1, 0, 0, 2, 0, 1, "R6 torus tie east");
    t_dir(1, 0, 0, 3, 0, 2, "R6 torus wrap west");
    t_dir(1, 0, 1, 0, 3, 3, "R6 torus tie north");
    t_dir(1, 0, 0, 0, 3, 4, "R6 torus wrap south");
    t_dir(1, 3, 3, 3, 3, 0, "R4 torus local");
    t_stall();
    t_contend();
    t_walk(1'b0);
    t_walk(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule